// File: doc/BRIEF.md
# Idle and Overload PE Selector

This block watches a vector of per-PE empty flags during one work round of a processing-element array. A flag is high while that PE has no pending tasks. Each cycle the block finds the PEs whose flag has just gone high and logs that vector into a small circular history. From this history it builds two ID lists. The first holds the first K PEs that went idle after the work source was fully handed out; these are the under-loaded set. The second holds the last K PEs to finish once every PE is empty; these are the over-loaded set. A rebalancing controller uses the two lists to decide which PEs should trade work in the next round.

A round begins with a one-cycle `round_start` pulse, which clears all state. A one-cycle `dispatch_done` pulse then arms the under-loaded scan. That scan reads the history from oldest to newest, one entry per cycle. The over-loaded scan starts once all PEs are empty and the first scan has finished or caught up with the history. It reads from newest to oldest, one entry per cycle. A one-cycle `lists_valid` pulse marks the end of the second scan.

Top module: `idle_overload_picker`

## Requirements
- R1: After reset, and in the cycle after a `round_start` pulse, both lists and both counts are zero and `lists_valid` is low.
- R2: A PE is logged only in a cycle where its empty flag is high and was low in the previous cycle. A PE that stays empty for the whole round never appears in either list.
- R3: `all_done` is high exactly when every bit of `pe_empty` is high, in the same cycle and with no register in the path.
- R4: After `dispatch_done`, `under_ids` fills with the IDs of the earliest logged PEs. Slot i sits at bits [i*IDW +: IDW], and slot 0 is the earliest. Filling stops at K, and `under_num` gives the number of filled slots.
- R5: PEs that go idle in the same cycle are placed in ascending index order, in both lists.
- R6: The over-loaded scan starts once all PEs are empty and the under-loaded scan is either full or caught up with the history. It fills `over_ids` from the newest log entry toward older ones, so slot 0 holds the last PE to finish. It stops at K IDs, and `over_num` gives the number of filled slots.
- R7: The history keeps the HIST_D most recent log entries, and a new entry overwrites the oldest. The under-loaded scan skips entries that have been overwritten, and the over-loaded scan reads no more than HIST_D entries.
- R8: `lists_valid` goes high for exactly one cycle when the over-loaded scan ends. Both lists then hold their values until the next `round_start`.
- R9: When fewer than K IDs can be found, the list ends short, its count reports how many were found, and the unused slots read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| round_start | input | 1 | One-cycle pulse that clears all round state |
| dispatch_done | input | 1 | One-cycle pulse: work source fully handed out, arms the under-loaded scan |
| pe_empty | input | N_PE | Per-PE flag, high when that PE's pending-task count is zero |
| all_done | output | 1 | High when every PE is empty |
| under_ids | output | K_SEL*IDW | Earliest-idle PE IDs, slot 0 first |
| under_num | output | CW | Number of valid slots in `under_ids` |
| over_ids | output | K_SEL*IDW | Last-finishing PE IDs, slot 0 is the latest |
| over_num | output | CW | Number of valid slots in `over_ids` |
| lists_valid | output | 1 | One-cycle pulse when both lists are final |

## Verification
A wrong previous-flag register or a bad write pointer in the history shows up within one scan cycle. It appears as a wrong or misordered ID in `under_ids` or `over_ids`, or as a count that grows when it should not. A scan pointer that gets lost during overwrite shows up as stale PE IDs in the under-loaded list as soon as the history has wrapped. A phase machine stuck in the wrong state shows up as a missing or repeated `lists_valid` pulse. The bench runs a behavioural model of the whole round next to the design and compares every output on every cycle, so any difference is caught in the cycle it first reaches a port.

// File: rtl/iop_pkg.sv
package iop_pkg;
   typedef enum logic [1:0] {
      PH_ARMED = 2'd0,
      PH_UNDER = 2'd1,
      PH_OVER  = 2'd2,
      PH_DONE  = 2'd3
   } iop_phase_t;
endpackage

// File: rtl/iop_edge_detect.sv
module iop_edge_detect #(
   parameter int N_PE = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_PE-1:0] pe_empty,
   output logic [N_PE-1:0] newly_idle
);
   logic [N_PE-1:0] prev_q;

   // prev starts all-ones so nothing is seen as a fresh edge out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= pe_empty;
   end

   // a changed bit that is now high means the PE just drained
   assign newly_idle = (pe_empty ^ prev_q) & pe_empty;
endmodule

// File: rtl/iop_history_ring.sv
module iop_history_ring #(
   parameter int N_PE   = 16,
   parameter int HIST_D = 8,
   localparam int HAW   = $clog2(HIST_D)
) (
   input  logic            clk,
   input  logic            wr_en,
   input  logic [HAW-1:0]  wr_addr,
   input  logic [N_PE-1:0] wr_data,
   input  logic [HAW-1:0]  rd_addr,
   output logic [N_PE-1:0] rd_data
);
   logic [N_PE-1:0] mem_q [HIST_D];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/iop_id_packer.sv
module iop_id_packer #(
   parameter int N_PE  = 16,
   parameter int K_SEL = 4,
   localparam int IDW  = $clog2(N_PE),
   localparam int CW   = $clog2(K_SEL + 1)
) (
   input  logic [N_PE-1:0]      vec,
   input  logic [CW-1:0]        cnt_in,
   input  logic [K_SEL*IDW-1:0] list_in,
   output logic [CW-1:0]        cnt_out,
   output logic [K_SEL*IDW-1:0] list_out
);
   always_comb begin
      int c;
      c        = int'(cnt_in);
      list_out = list_in;
      for (int i = 0; i < N_PE; i++) begin
         if (vec[i] && (c < K_SEL)) begin
            list_out[c*IDW +: IDW] = IDW'(i);
            c = c + 1;
         end
      end
      cnt_out = CW'(c);
   end
endmodule

// File: rtl/idle_overload_picker.sv
module idle_overload_picker
   import iop_pkg::*;
#(
   parameter int N_PE   = 16,
   parameter int K_SEL  = 4,
   parameter int HIST_D = 8,
   parameter int SEQ_W  = 16,
   localparam int IDW   = $clog2(N_PE),
   localparam int CW    = $clog2(K_SEL + 1),
   localparam int HAW   = $clog2(HIST_D)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 round_start,
   input  logic                 dispatch_done,
   input  logic [N_PE-1:0]      pe_empty,
   output logic                 all_done,
   output logic [K_SEL*IDW-1:0] under_ids,
   output logic [CW-1:0]        under_num,
   output logic [K_SEL*IDW-1:0] over_ids,
   output logic [CW-1:0]        over_num,
   output logic                 lists_valid
);
   localparam logic [CW-1:0]    K_C     = CW'(K_SEL);
   localparam logic [SEQ_W-1:0] DEPTH_S = SEQ_W'(HIST_D);
   localparam logic [HAW:0]     DEPTH_L = (HAW+1)'(HIST_D);

   generate
      if (N_PE < 2) begin : g_bad_npe
         $error("N_PE must be at least 2");
      end
      if ((K_SEL < 1) || (K_SEL > N_PE)) begin : g_bad_k
         $error("K_SEL must lie in 1..N_PE");
      end
      if ((HIST_D < 2) || ((HIST_D & (HIST_D - 1)) != 0)) begin : g_bad_depth
         $error("HIST_D must be a power of two, at least 2");
      end
      if (SEQ_W <= HAW + 1) begin : g_bad_seq
         $error("SEQ_W too narrow for HIST_D");
      end
   endgenerate

   iop_phase_t        phase_q;
   logic [SEQ_W-1:0]  total_q, scan_q, over_seq_q;
   logic [HAW:0]      over_left_q;
   logic [N_PE-1:0]   newly_idle, rd_data;
   logic              push, under_go, over_go;
   logic [SEQ_W-1:0]  oldest, seq_eff;
   logic [HAW-1:0]    rd_addr;
   logic [CW-1:0]     u_cnt_nxt, o_cnt_nxt;
   logic [K_SEL*IDW-1:0] u_list_nxt, o_list_nxt;

   iop_edge_detect #(.N_PE(N_PE)) u_edge (
      .clk(clk), .rst_n(rst_n), .pe_empty(pe_empty), .newly_idle(newly_idle)
   );

   assign all_done = &pe_empty;
   assign push     = (|newly_idle) && ((phase_q == PH_ARMED) || (phase_q == PH_UNDER));
   assign oldest   = (total_q >= DEPTH_S) ? (total_q - DEPTH_S) : '0;
   assign seq_eff  = (scan_q < oldest) ? oldest : scan_q;
   assign under_go = (phase_q == PH_UNDER) && (under_num < K_C) && (scan_q < total_q);
   assign over_go  = (phase_q == PH_OVER) && (over_left_q != '0) && (over_num < K_C);
   assign rd_addr  = under_go ? seq_eff[HAW-1:0] : over_seq_q[HAW-1:0];

   iop_history_ring #(.N_PE(N_PE), .HIST_D(HIST_D)) u_ring (
      .clk(clk), .wr_en(push), .wr_addr(total_q[HAW-1:0]), .wr_data(newly_idle),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   iop_id_packer #(.N_PE(N_PE), .K_SEL(K_SEL)) u_pack_under (
      .vec(rd_data), .cnt_in(under_num), .list_in(under_ids),
      .cnt_out(u_cnt_nxt), .list_out(u_list_nxt)
   );

   iop_id_packer #(.N_PE(N_PE), .K_SEL(K_SEL)) u_pack_over (
      .vec(rd_data), .cnt_in(over_num), .list_in(over_ids),
      .cnt_out(o_cnt_nxt), .list_out(o_list_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_ARMED;
         total_q     <= '0;
         scan_q      <= '0;
         over_seq_q  <= '0;
         over_left_q <= '0;
         under_ids   <= '0;
         under_num   <= '0;
         over_ids    <= '0;
         over_num    <= '0;
         lists_valid <= 1'b0;
      end else if (round_start) begin
         phase_q     <= PH_ARMED;
         total_q     <= '0;
         scan_q      <= '0;
         over_seq_q  <= '0;
         over_left_q <= '0;
         under_ids   <= '0;
         under_num   <= '0;
         over_ids    <= '0;
         over_num    <= '0;
         lists_valid <= 1'b0;
      end else begin
         lists_valid <= 1'b0;
         if (push) total_q <= total_q + SEQ_W'(1);
         unique case (phase_q)
            PH_ARMED: begin
               if (dispatch_done) phase_q <= PH_UNDER;
            end
            PH_UNDER: begin
               if (under_go) begin
                  under_ids <= u_list_nxt;
                  under_num <= u_cnt_nxt;
                  scan_q    <= seq_eff + SEQ_W'(1);
               end else if (all_done && !push) begin
                  phase_q     <= PH_OVER;
                  over_seq_q  <= total_q - SEQ_W'(1);
                  over_left_q <= (total_q >= DEPTH_S) ? DEPTH_L : total_q[HAW:0];
               end
            end
            PH_OVER: begin
               if (over_go) begin
                  over_ids    <= o_list_nxt;
                  over_num    <= o_cnt_nxt;
                  over_seq_q  <= over_seq_q - SEQ_W'(1);
                  over_left_q <= over_left_q - (HAW+1)'(1);
               end else begin
                  phase_q     <= PH_DONE;
                  lists_valid <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/iop_checker.sv
module iop_checker #(
   parameter int N_PE  = 16,
   parameter int K_SEL = 4,
   localparam int IDW  = $clog2(N_PE),
   localparam int CW   = $clog2(K_SEL + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 round_start,
   input logic [K_SEL*IDW-1:0] under_ids,
   input logic [CW-1:0]        under_num,
   input logic [K_SEL*IDW-1:0] over_ids,
   input logic [CW-1:0]        over_num,
   input logic                 lists_valid
);
   localparam logic [CW-1:0] K_C = CW'(K_SEL);

   // R1
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_start |=> (under_num == '0) && (over_num == '0) && !lists_valid);

   // R8
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lists_valid |=> !lists_valid);

   // R8
   under_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lists_valid |-> $stable(under_ids) && $stable(under_num));

   // R8
   over_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lists_valid && !round_start) |=> $stable(over_ids) && $stable(over_num));

   // R4
   under_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      under_num <= K_C);

   // R6
   over_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !round_start |=> (over_num >= $past(over_num)) && (over_num <= K_C));
endmodule

bind idle_overload_picker iop_checker #(.N_PE(N_PE), .K_SEL(K_SEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .round_start(round_start),
   .under_ids(under_ids), .under_num(under_num),
   .over_ids(over_ids), .over_num(over_num), .lists_valid(lists_valid)
);

// File: tb/idle_overload_picker_tb.sv
`timescale 1ns/1ps
module idle_overload_picker_tb;
   localparam int N   = 16;
   localparam int K   = 4;
   localparam int D   = 8;
   localparam int IDW = 4;
   localparam int CW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rs = 1'b0, dd = 1'b0;
   logic [N-1:0] emp = '1;
   logic all_done, lists_valid;
   logic [K*IDW-1:0] under_ids, over_ids;
   logic [CW-1:0] under_num, over_num;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   idle_overload_picker u_dut (
      .clk(clk), .rst_n(rst_n), .round_start(rs), .dispatch_done(dd),
      .pe_empty(emp), .all_done(all_done), .under_ids(under_ids),
      .under_num(under_num), .over_ids(over_ids), .over_num(over_num),
      .lists_valid(lists_valid)
   );

   // ---------------- behavioural reference ----------------
   logic [N-1:0] hist[$];
   logic [N-1:0] m_prev, m_nv;
   int m_phase, m_scan, m_over, m_left, m_un, m_on, m_tot, m_s;
   int m_ul[K], m_ol[K];
   bit m_valid, m_psh;

   task automatic m_clear();
      hist.delete();
      m_phase = 0; m_scan = 0; m_over = 0; m_left = 0;
      m_un = 0; m_on = 0; m_valid = 0;
      for (int i = 0; i < K; i++) begin m_ul[i] = 0; m_ol[i] = 0; end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_clear();
         m_prev = '1;
      end else if (rs) begin
         m_clear();
         m_prev = emp;
      end else begin
         m_nv    = emp & ~m_prev;
         m_tot   = hist.size();
         m_psh   = (m_nv != 0) && (m_phase <= 1);
         m_valid = 0;
         case (m_phase)
            0: if (dd) m_phase = 1;
            1: begin
               if (m_un < K && m_scan < m_tot) begin
                  m_s = (m_tot - D > m_scan) ? m_tot - D : m_scan;
                  for (int i = 0; i < N; i++)
                     if (hist[m_s][i] && m_un < K) begin m_ul[m_un] = i; m_un++; end
                  m_scan = m_s + 1;
               end else if ((&emp) && !m_psh) begin
                  m_phase = 2;
                  m_over  = m_tot - 1;
                  m_left  = (m_tot < D) ? m_tot : D;
               end
            end
            2: begin
               if (m_left > 0 && m_on < K) begin
                  for (int i = 0; i < N; i++)
                     if (hist[m_over][i] && m_on < K) begin m_ol[m_on] = i; m_on++; end
                  m_over--; m_left--;
               end else begin
                  m_phase = 3; m_valid = 1;
               end
            end
            default: ;
         endcase
         if (m_psh) hist.push_back(m_nv);
         m_prev = emp;
      end
   end

   function automatic logic [K*IDW-1:0] pack_arr(int a[K]);
      logic [K*IDW-1:0] r = '0;
      for (int i = 0; i < K; i++) r[i*IDW +: IDW] = IDW'(a[i]);
      return r;
   endfunction

   function automatic logic [K*IDW-1:0] pack4(int a, int b, int c, int d);
      return {IDW'(d), IDW'(c), IDW'(b), IDW'(a)};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R3 all_done", 64'(all_done), 64'(&emp));
         chk("R4 under_ids", 64'(under_ids), 64'(pack_arr(m_ul)));
         chk("R4 under_num", 64'(under_num), 64'(m_un));
         chk("R6 over_ids", 64'(over_ids), 64'(pack_arr(m_ol)));
         chk("R6 over_num", 64'(over_num), 64'(m_on));
         chk("R8 lists_valid", 64'(lists_valid), 64'(m_valid));
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic begin_round(logic [N-1:0] start_emp);
      emp = start_emp;
      rs  = 1'b1;
      tick();
      rs  = 1'b0;
      chk("R1 under_num after start", 64'(under_num), 64'd0);
      chk("R1 valid after start", 64'(lists_valid), 64'd0);
   endtask

   task automatic pulse_dispatch();
      dd = 1'b1;
      tick();
      dd = 1'b0;
   endtask

   task automatic wait_valid(string req);
      bit seen = 0;
      for (int t = 0; t < 60; t++) begin
         tick();
         if (lists_valid) begin seen = 1; break; end
      end
      chk(req, 64'(seen), 64'd1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int order_a[N] = '{5, 3, 12, 0, 9, 1, 2, 4, 6, 7, 8, 10, 11, 13, 14, 15};
      repeat (3) tick();
      // R1: reset state
      chk("R1 reset under_ids", 64'(under_ids), 64'd0);
      chk("R1 reset over_num", 64'(over_num), 64'd0);
      chk("R1 reset valid", 64'(lists_valid), 64'd0);
      rst_n = 1'b1;
      tick();

      // Round A: one PE drains per cycle
      begin_round('0);
      pulse_dispatch();
      for (int p = 0; p < N; p++) begin
         emp[order_a[p]] = 1'b1;
         if (p == N - 2) begin
            #1 chk("R3 not all empty", 64'(all_done), 64'd0);
         end
         tick();
      end
      chk("R3 all empty", 64'(all_done), 64'd1);
      wait_valid("R8 valid round A");
      chk("R4 earliest four", 64'(under_ids), 64'(pack4(5, 3, 12, 0)));
      chk("R6 latest four", 64'(over_ids), 64'(pack4(15, 14, 13, 11)));
      tick();
      chk("R8 valid one cycle", 64'(lists_valid), 64'd0);
      chk("R8 lists held", 64'(under_ids), 64'(pack4(5, 3, 12, 0)));

      // Round B: simultaneous drains
      begin_round('0);
      pulse_dispatch();
      emp[2] = 1'b1; emp[7] = 1'b1; emp[9] = 1'b1;
      tick();
      emp[1] = 1'b1;
      tick();
      emp = '1;
      tick();
      wait_valid("R8 valid round B");
      chk("R5 same-cycle ascending under", 64'(under_ids), 64'(pack4(2, 7, 9, 1)));
      chk("R5 same-cycle ascending over", 64'(over_ids), 64'(pack4(0, 3, 4, 5)));

      // Round C: history wraps before the under scan starts
      begin_round('0);
      for (int p = 0; p < N; p++) begin
         emp[p] = 1'b1;
         tick();
      end
      pulse_dispatch();
      wait_valid("R8 valid round C");
      chk("R7 overwritten entries skipped", 64'(under_ids), 64'(pack4(8, 9, 10, 11)));
      chk("R7 over from newest", 64'(over_ids), 64'(pack4(15, 14, 13, 12)));

      // Round D: only two PEs ever busy
      begin_round(16'hFFAF);
      pulse_dispatch();
      emp[6] = 1'b1;
      tick();
      emp[4] = 1'b1;
      tick();
      wait_valid("R8 valid round D");
      chk("R2 idle-from-start not logged", 64'(under_num), 64'd2);
      chk("R9 short under list", 64'(under_ids), 64'(pack4(6, 4, 0, 0)));
      chk("R9 short over list", 64'(over_ids), 64'(pack4(4, 6, 0, 0)));
      chk("R9 short over count", 64'(over_num), 64'd2);

      // Round E: restart in the middle of a round
      begin_round('0);
      pulse_dispatch();
      emp[1] = 1'b1;
      tick();
      emp[2] = 1'b1;
      tick();
      tick();
      chk("R4 partial under", 64'(under_num), 64'd2);
      begin_round('0);
      chk("R1 restart clears ids", 64'(under_ids), 64'd0);
      tick();
      chk("R1 restart stays clear", 64'(under_num), 64'd0);

      repeat (3) tick();
      finish_run();
   end
endmodule